// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block sits between a register front end and a bit-level I2C controller. It breaks whole-byte transfers down into single bit operations. A command is loaded with one strobe. The strobe carries request flags for a start condition, a stop condition, a byte write and a byte read, plus the acknowledge value to send after a read. The strobe also latches a transmit byte. The sequencer then issues bit commands one at a time. Each bit command is held until the bit controller reports it complete. Between bit commands the sequencer shifts data through an internal shift register.

The order of a sequence is fixed: optional start, then the data bits most significant first, then one acknowledge bit, then optional stop. On a write, the transmit byte goes out and the slave's acknowledge is sampled into a status flag. On a read, the incoming bits are collected, and the finished byte is copied into a receive register that a write never touches. The master then sends its acknowledge bit. When the sequence ends, the request flags clear themselves, a one-cycle done pulse appears, and an interrupt flag is set that stays set until software clears it.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset, bit_cmd is 0 (idle), and busy, done, irq, rx_ack and rx_data are all 0.
- R2: A write issues DATA_W bit commands of code 3 (write bit). On each one, bit_din carries the latched transmit byte, most significant bit first. One bit command of code 4 (read bit) follows for the slave acknowledge.
- R3: On a write, the bit_dout returned by the acknowledge read is stored in rx_ack: 0 means acknowledged, 1 means not acknowledged.
- R4: When start is requested with a data flag, one bit command of code 1 (start) comes before the data bits.
- R5: A read issues DATA_W bit commands of code 4 and assembles the returned bits into rx_data, first bit into the most significant position. It then issues one command of code 3 with bit_din equal to the requested acknowledge value (0 = ACK, 1 = NACK). A read leaves rx_ack unchanged.
- R6: When stop is requested, one bit command of code 2 (stop) is issued last, after the acknowledge phase. A stop-only command issues just that one code.
- R7: Completion raises done for exactly one cycle, and busy (any request flag pending) is low from that cycle on.
- R8: irq rises together with done and stays high until irq_clr is asserted.
- R9: A cmd_we strobe while busy is ignored: neither the bit sequence in progress nor its data changes.
- R10: The transmit byte is latched at cmd_we, so later changes on tx_data do not alter the bits sent.
- R11: A non-idle bit_cmd and its bit_din stay stable until bit_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Load command flags and transmit byte |
| cmd_start | input | 1 | Request a start condition |
| cmd_stop | input | 1 | Request a stop condition |
| cmd_write | input | 1 | Request a byte write |
| cmd_read | input | 1 | Request a byte read |
| cmd_ack_bit | input | 1 | Acknowledge value to send after a read |
| tx_data | input | DATA_W | Transmit byte |
| irq_clr | input | 1 | Clear the interrupt flag |
| bit_cmd | output | 3 | Bit command: 0 idle, 1 start, 2 stop, 3 write bit, 4 read bit |
| bit_din | output | 1 | Bit value for write-bit commands |
| bit_done | input | 1 | Bit controller finished the current command |
| bit_dout | input | 1 | Bit sampled by the bit controller on a read bit |
| rx_data | output | DATA_W | Last received byte |
| rx_ack | output | 1 | Acknowledge received from the slave |
| busy | output | 1 | A command is pending |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with DATA_W = 8. It pairs the block with a behavioral bit controller that answers each command after a fixed two-cycle latency and feeds back bits from a scripted pattern. This setup makes every part of the bit sequence reachable: the start and stop framing, the full eight-bit shift, both acknowledge polarities in each direction, and a stop-only command. The latency leaves idle cycles in the middle of a transfer. The bench uses them to fire a stray command strobe and to change the transmit byte while a byte is in flight.

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_write,
  input  logic              cmd_read,
  input  logic              cmd_ack_bit,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              irq_clr,
  output logic [2:0]        bit_cmd,
  output logic              bit_din,
  input  logic              bit_done,
  input  logic              bit_dout,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ack,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [2:0] BC_IDLE = 3'd0, BC_START = 3'd1, BC_STOP = 3'd2,
                         BC_WR = 3'd3, BC_RD = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_ACK, S_STOP} state_t;
  state_t state;

  logic f_start, f_stop, f_wr, f_rd, f_ackbit;
  logic [DATA_W-1:0] tx_q, sr, rx_q;
  logic [CW-1:0] cnt;
  logic ack_q, done_q, irq_q, fin;

  assign busy    = f_start | f_stop | f_wr | f_rd;
  assign rx_data = rx_q;
  assign rx_ack  = ack_q;
  assign done    = done_q;
  assign irq     = irq_q;

  assign fin = bit_done && ((state == S_START && !(f_wr || f_rd)) ||
                            (state == S_ACK && !f_stop) ||
                            (state == S_STOP));

  always_comb begin
    case (state)
      S_START: bit_cmd = BC_START;
      S_STOP:  bit_cmd = BC_STOP;
      S_XFER:  bit_cmd = f_rd ? BC_RD : BC_WR;
      S_ACK:   bit_cmd = f_rd ? BC_WR : BC_RD;
      default: bit_cmd = BC_IDLE;
    endcase
  end

  assign bit_din = (state == S_XFER) ? sr[DATA_W-1] :
                   (state == S_ACK)  ? f_ackbit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {f_start, f_stop, f_wr, f_rd, f_ackbit} <= '0;
      tx_q <= '0; sr <= '0; rx_q <= '0; cnt <= '0;
      ack_q <= 1'b0; done_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      done_q <= fin;
      irq_q  <= fin ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
      case (state)
        S_IDLE: begin
          if (cmd_we && !busy) begin
            {f_start, f_stop, f_wr, f_rd} <= {cmd_start, cmd_stop, cmd_write, cmd_read};
            f_ackbit <= cmd_ack_bit;
            tx_q     <= tx_data;
          end else if (busy) begin
            if (f_start) state <= S_START;
            else if (f_wr || f_rd) begin
              state <= S_XFER; sr <= tx_q; cnt <= CW'(DATA_W - 1);
            end else state <= S_STOP;
          end
        end
        S_START: if (bit_done && (f_wr || f_rd)) begin
          state <= S_XFER; sr <= tx_q; cnt <= CW'(DATA_W - 1);
        end
        S_XFER: if (bit_done) begin
          sr <= {sr[DATA_W-2:0], bit_dout};
          if (cnt == '0) state <= S_ACK;
          else cnt <= cnt - 1'b1;
        end
        S_ACK: if (bit_done) begin
          if (f_rd) rx_q <= sr;
          else ack_q <= bit_dout;
          if (f_stop) state <= S_STOP;
        end
        default: ;
      endcase
      if (fin) begin
        state <= S_IDLE;
        {f_start, f_stop, f_wr, f_rd} <= '0;
      end
    end
  end

  p_hold_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cmd != BC_IDLE && !bit_done) |=> ($stable(bit_cmd) && $stable(bit_din)));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bit_cmd == BC_IDLE));
endmodule

// File: tb/i2c_byte_seq_tb.sv
module i2c_byte_seq_tb_top;
  localparam int DW = 8;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0, cmd_ack_bit = 0;
  logic [DW-1:0] tx_data = '0;
  logic irq_clr = 0;
  logic [2:0] bit_cmd;
  logic bit_din, bit_done, bit_dout;
  logic [DW-1:0] rx_data;
  logic rx_ack, busy, done, irq;

  int checks = 0, failures = 0;
  logic [15:0] rd_src = '0;

  always #2 clk = ~clk;

  i2c_byte_seq #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_write(cmd_write), .cmd_read(cmd_read), .cmd_ack_bit(cmd_ack_bit), .tx_data(tx_data),
    .irq_clr(irq_clr), .bit_cmd(bit_cmd), .bit_din(bit_din), .bit_done(bit_done),
    .bit_dout(bit_dout), .rx_data(rx_data), .rx_ack(rx_ack), .busy(busy), .done(done), .irq(irq));

  logic [2:0] log_cmd [0:511];
  logic       log_din [0:511];
  int log_n = 0, wait_cnt = 0, rd_idx = 0;

  always @(posedge clk) begin
    bit_done <= 1'b0;
    if (!rst_n) begin
      wait_cnt <= 0; rd_idx <= 0; bit_dout <= 1'b0;
    end else begin
      if (done) rd_idx <= 0;
      if (bit_cmd != 3'd0 && !bit_done) begin
        if (wait_cnt == LAT) begin
          bit_done <= 1'b1;
          wait_cnt <= 0;
          log_cmd[log_n % 512] <= bit_cmd;
          log_din[log_n % 512] <= bit_din;
          log_n <= log_n + 1;
          if (bit_cmd == 3'd4) begin
            bit_dout <= rd_src[15 - rd_idx];
            rd_idx <= rd_idx + 1;
          end
        end else wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
  endtask

  task automatic issue(input bit st, input bit sp, input bit wr, input bit rd, input bit ab,
                       input logic [DW-1:0] d);
    @(negedge clk);
    cmd_start = st; cmd_stop = sp; cmd_write = wr; cmd_read = rd; cmd_ack_bit = ab;
    tx_data = d; cmd_we = 1;
    @(negedge clk);
    cmd_we = 0; cmd_start = 0; cmd_stop = 0; cmd_write = 0; cmd_read = 0; cmd_ack_bit = 0;
  endtask

  task automatic wait_done(input bit disturb, output int pulses);
    int n = 0;
    pulses = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (disturb && i == 10) begin
        tx_data = ~tx_data; cmd_we = 1; cmd_read = 1; cmd_stop = 1;
      end else if (disturb && i == 11) begin
        cmd_we = 0; cmd_read = 0; cmd_stop = 0;
      end
      if (done) begin
        pulses++;
        chk(!busy, "R7 busy low at done", busy, 0);
        chk(irq, "R8 irq with done", irq, 1);
        n = i;
        break;
      end
    end
    @(negedge clk);
    if (done) pulses++;
    chk(pulses == 1, "R7 single done pulse", pulses, 1);
  endtask

  task automatic t_reset();
    chk(bit_cmd == 0 && !busy && !done && !irq && !rx_ack && rx_data == 0,
        "R1 reset state", {bit_cmd, busy, done, irq, rx_ack}, 0);
  endtask

  task automatic t_write(input bit st, input bit sp, input logic [DW-1:0] d, input bit sack,
                         input bit disturb, input string tag);
    int base, k, p;
    bit ok;
    logic [DW-1:0] rx_before;
    clear_irq();
    rd_src = {sack, 15'b0};
    rx_before = rx_data;
    base = log_n;
    issue(st, sp, 1, 0, 0, d);
    wait_done(disturb, p);
    k = base;
    if (st) begin
      chk(log_cmd[k % 512] == 3'd1, {"R4 start first ", tag}, log_cmd[k % 512], 1);
      k++;
    end
    ok = 1;
    for (int i = 0; i < DW; i++) begin
      if (log_cmd[k % 512] != 3'd3 || log_din[k % 512] != d[DW-1-i]) ok = 0;
      k++;
    end
    chk(ok, {"R2 R10 R9 write bits msb first ", tag}, log_n - base, d);
    chk(log_cmd[k % 512] == 3'd4, {"R2 ack read bit ", tag}, log_cmd[k % 512], 4);
    k++;
    if (sp) begin
      chk(log_cmd[k % 512] == 3'd2, {"R6 stop last ", tag}, log_cmd[k % 512], 2);
      k++;
    end
    chk(log_n == k, {"R9 command count ", tag}, log_n - base, k - base);
    chk(rx_ack == sack, {"R3 slave ack captured ", tag}, rx_ack, sack);
    chk(rx_data == rx_before, {"R9 rx untouched by write ", tag}, rx_data, rx_before);
  endtask

  task automatic t_read(input bit sp, input logic [DW-1:0] d, input bit ab, input string tag);
    int base, k, p;
    bit ok;
    logic ack_before;
    clear_irq();
    rd_src = {d, 8'b0};
    ack_before = rx_ack;
    base = log_n;
    issue(0, sp, 0, 1, ab, 8'h00);
    wait_done(0, p);
    k = base;
    ok = 1;
    for (int i = 0; i < DW; i++) begin
      if (log_cmd[k % 512] != 3'd4) ok = 0;
      k++;
    end
    chk(ok, {"R5 eight read bits ", tag}, log_n - base, DW);
    chk(log_cmd[k % 512] == 3'd3 && log_din[k % 512] == ab, {"R5 master ack bit ", tag},
        {log_cmd[k % 512], log_din[k % 512]}, {3'd3, ab});
    k++;
    if (sp) begin
      chk(log_cmd[k % 512] == 3'd2, {"R6 stop after ack ", tag}, log_cmd[k % 512], 2);
      k++;
    end
    chk(log_n == k, {"R5 command count ", tag}, log_n - base, k - base);
    chk(rx_data == d, {"R5 received byte ", tag}, rx_data, d);
    chk(rx_ack == ack_before, {"R5 rx_ack unchanged ", tag}, rx_ack, ack_before);
  endtask

  task automatic t_stop_only();
    int base, p;
    clear_irq();
    base = log_n;
    issue(0, 1, 0, 0, 0, 8'h00);
    wait_done(0, p);
    chk(log_n - base == 1 && log_cmd[base % 512] == 3'd2, "R6 stop only",
        log_n - base, 1);
  endtask

  task automatic t_irq_hold();
    repeat (20) @(negedge clk);
    chk(irq == 1, "R8 irq sticky", irq, 1);
    chk(bit_cmd == 0, "R11 idle after completion", bit_cmd, 0);
    clear_irq();
    @(negedge clk);
    chk(irq == 0, "R8 irq cleared", irq, 0);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_write(1, 0, 8'hA5, 1'b0, 0, "addr");
    t_write(0, 1, 8'h3C, 1'b1, 0, "nack");
    t_write(1, 1, 8'h81, 1'b0, 1, "disturbed");
    t_read(0, 8'hC6, 1'b0, "ack");
    t_read(1, 8'h5B, 1'b1, "nack stop");
    t_stop_only();
    t_irq_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule